// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command pins from reset until the memory has been brought up. Software arms it by raising an init bit in its control register. The bring-up does not start at reset. It starts when a write to the SDRAM address window arrives while that bit is set. That write only acts as a trigger, and its data is never passed on. The block then waits out the device power-up interval. It issues one precharge-all, a fixed train of auto-refresh commands and a load-mode command. The load-mode command carries the mode word on the address pins, so every device on the bus is programmed in the same cycle.

The mode word always selects a burst length of one, which turns the device's own burst off. Its CAS latency comes from the latency field of the timing configuration. When the last gap has elapsed, the block raises its active flag and acknowledges the trigger write. From then on, requests pass straight to the normal access engine. Until that point, any pending access waits with its acknowledge held low. It is never lost.

Top module: `sdram_boot_seq`

## Requirements
- R1: Out of reset, all command pins read NOP (cs_n/ras_n/cas_n/we_n = 0/1/1/1), and `stat_active`, `req_ack` and `fwd_valid` are low.
- R2: A sequence starts only on a write (`req_we`=1) whose address lies in the window `MEM_BASE` of size 2^`WIN_LOG2` bytes, with `cfg_init` high in that cycle. Reads, and writes outside the window, issue no command.
- R3: After the triggering edge, exactly ceil(`CLK_HZ` x `PWRUP_NS` / 1e9) NOP cycles pass before the first command.
- R4: The first command is a single precharge-all (0/0/1/0 with `sd_addr[10]`=1, other address bits 0). It is followed by `T_RP` NOP cycles.
- R5: Exactly `N_REF` (default 8) auto-refresh commands (0/0/0/1, address 0) follow. Each one is followed by `T_RFC` NOP cycles.
- R6: After the last refresh gap, one load-mode command (0/0/0/0, `sd_ba`=0) is issued. Its address carries `sd_addr[2:0]`=000 (burst length one), `sd_addr[3]`=0, `sd_addr[6:4]`={0,`cfg_cas_lat`}, and all other bits 0.
- R7: `stat_active` rises after `T_MRD` NOP cycles that follow the load-mode command, and it stays high until reset.
- R8: The trigger write is acknowledged by a single `req_ack` pulse in the first cycle in which `stat_active` is high. It is never forwarded (`fwd_valid` low).
- R9: While `stat_active` is low, `req_ack` and `fwd_valid` stay low for any held request.
- R10: While `stat_active` is high (apart from the trigger acknowledge cycle), `fwd_valid` follows `req_valid` and `req_ack` follows `eng_ack`.
- R11: Dropping `cfg_init` during a running sequence leaves the command train and its timing unchanged.
- R12: Once `stat_active` is high, a renewed arming followed by a window write issues no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_init | input | 1 | Init (arm) bit from the control register |
| cfg_cas_lat | input | 2 | CAS latency field of the timing register |
| req_valid | input | 1 | Host access request |
| req_we | input | 1 | Request is a write |
| req_addr | input | AW | Request byte address |
| req_ack | output | 1 | Request acknowledge to the host |
| fwd_valid | output | 1 | Request passed to the access engine |
| eng_ack | input | 1 | Acknowledge from the access engine |
| stat_active | output | 1 | Initialization complete status flag |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ba | output | BA_W | SDRAM bank address |
| sd_addr | output | RA_W | SDRAM address pins |

## Verification
The command pins and the status flag are all decoded from the state register, so each result is visible one edge after the transition that causes it. The precharge-all appears 5000 NOP cycles after the trigger edge (20 ns clock, 100 µs). Each later command follows its predecessor after exactly `T_RP` or `T_RFC` NOP cycles. The active flag and the trigger acknowledge follow the load-mode command after `T_MRD` NOP cycles. The bench queues each expected command together with the NOP gap that must precede it. A monitor samples on the falling edge, counts NOP cycles since the trigger was driven and compares every command against the queue head. Any command seen while the queue is empty is a failure.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POWERUP,
    ST_PRECHG,
    ST_GAP_RP,
    ST_REFRESH,
    ST_GAP_RFC,
    ST_LOADMODE,
    ST_GAP_MRD,
    ST_READY
  } boot_state_e;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRECHARGE,
    CMD_REFRESH,
    CMD_LOADMODE
  } boot_cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  // Pin pattern for each command, ordered cs/ras/cas/we.
  function automatic cmd_pins_t encode_cmd(boot_cmd_e c);
    case (c)
      CMD_PRECHARGE: return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_REFRESH:   return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      CMD_LOADMODE:  return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default:       return '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
  endfunction

  // Cycles needed to cover a time span, rounded up.
  function automatic longint unsigned span_to_cycles(longint unsigned hz,
                                                     longint unsigned ns);
    return (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
  endfunction

  function automatic longint unsigned max4(longint unsigned a, longint unsigned b,
                                           longint unsigned c, longint unsigned d);
    longint unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sbs_timer.sv
module sbs_timer #(
  parameter int TW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R3: an expired count never wraps back into a new wait by itself.
  a_r3_timer_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);

endmodule

// File: rtl/sbs_mode_word.sv
module sbs_mode_word #(
  parameter int RA_W = 13
) (
  input  logic [1:0]      cas_lat,
  output logic [RA_W-1:0] word
);
  always_comb begin
    word      = '0;
    word[2:0] = 3'b000;            // burst length one
    word[3]   = 1'b0;              // sequential ordering
    word[6:4] = {1'b0, cas_lat};   // CAS latency
  end
endmodule

// File: rtl/sbs_cmd_drive.sv
module sbs_cmd_drive
  import sdram_boot_pkg::*;
#(
  parameter int RA_W = 13,
  parameter int BA_W = 2
) (
  input  boot_cmd_e       cmd,
  input  logic [RA_W-1:0] mode_word,
  output cmd_pins_t       pins,
  output logic [BA_W-1:0] ba,
  output logic [RA_W-1:0] addr
);
  always_comb begin
    pins = encode_cmd(cmd);
    ba   = '0;
    addr = '0;
    case (cmd)
      CMD_PRECHARGE: addr[10] = 1'b1;   // all banks
      CMD_LOADMODE:  addr = mode_word;
      default:       addr = '0;
    endcase
  end
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned PWRUP_NS = 100_000,
  parameter int unsigned T_RP     = 3,
  parameter int unsigned T_RFC    = 7,
  parameter int unsigned T_MRD    = 2,
  parameter int unsigned N_REF    = 8,
  parameter int          AW       = 32,
  parameter int          RA_W     = 13,
  parameter int          BA_W     = 2,
  parameter int          WIN_LOG2 = 25,
  parameter logic [AW-1:0] MEM_BASE = 32'h4000_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_init,
  input  logic [1:0]      cfg_cas_lat,
  input  logic            req_valid,
  input  logic            req_we,
  input  logic [AW-1:0]   req_addr,
  output logic            req_ack,
  output logic            fwd_valid,
  input  logic            eng_ack,
  output logic            stat_active,
  output logic            sd_cs_n,
  output logic            sd_ras_n,
  output logic            sd_cas_n,
  output logic            sd_we_n,
  output logic [BA_W-1:0] sd_ba,
  output logic [RA_W-1:0] sd_addr
);
  localparam longint unsigned PU_CYC = span_to_cycles(CLK_HZ, PWRUP_NS);
  localparam longint unsigned MAXV   = max4(PU_CYC, T_RP, T_RFC, T_MRD);
  localparam int TW  = $clog2(MAXV + 1);
  localparam int RCW = $clog2(N_REF + 1);
  localparam logic [TW-1:0] LD_PU  = TW'(PU_CYC - 1);
  localparam logic [TW-1:0] LD_RP  = TW'(T_RP - 1);
  localparam logic [TW-1:0] LD_RFC = TW'(T_RFC - 1);
  localparam logic [TW-1:0] LD_MRD = TW'(T_MRD - 1);
  localparam logic [RCW-1:0] REF_LAST = RCW'(N_REF);

  boot_state_e    state_q, state_d;
  logic [RCW-1:0] ref_cnt_q;
  logic           active_q, ack_q;
  logic           tmr_load, tmr_zero;
  logic [TW-1:0]  tmr_val;
  logic           in_win, start;
  boot_cmd_e      cmd;
  cmd_pins_t      pins;
  logic [RA_W-1:0] mode_word;

  // Named events for the checks
  logic ev_pre, ev_ref, ev_mrs, ev_done;

  assign in_win = ((req_addr ^ MEM_BASE) >> WIN_LOG2) == '0;
  assign start  = (state_q == ST_IDLE) && cfg_init && req_valid && req_we && in_win;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE:     if (start) begin
                     state_d = ST_POWERUP; tmr_load = 1'b1; tmr_val = LD_PU;
                   end
      ST_POWERUP:  if (tmr_zero) state_d = ST_PRECHG;
      ST_PRECHG:   begin state_d = ST_GAP_RP; tmr_load = 1'b1; tmr_val = LD_RP; end
      ST_GAP_RP:   if (tmr_zero) state_d = ST_REFRESH;
      ST_REFRESH:  begin state_d = ST_GAP_RFC; tmr_load = 1'b1; tmr_val = LD_RFC; end
      ST_GAP_RFC:  if (tmr_zero) state_d = (ref_cnt_q == REF_LAST) ? ST_LOADMODE : ST_REFRESH;
      ST_LOADMODE: begin state_d = ST_GAP_MRD; tmr_load = 1'b1; tmr_val = LD_MRD; end
      ST_GAP_MRD:  if (tmr_zero) state_d = ST_READY;
      default:     state_d = ST_READY;
    endcase
  end

  assign ev_pre  = (state_q == ST_PRECHG);
  assign ev_ref  = (state_q == ST_REFRESH);
  assign ev_mrs  = (state_q == ST_LOADMODE);
  assign ev_done = (state_q == ST_GAP_MRD) && tmr_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ref_cnt_q <= '0;
      active_q  <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_ref) ref_cnt_q <= ref_cnt_q + 1'b1;
      if (ev_done) active_q <= 1'b1;
      ack_q <= ev_done;
    end
  end

  always_comb begin
    if (ev_pre)      cmd = CMD_PRECHARGE;
    else if (ev_ref) cmd = CMD_REFRESH;
    else if (ev_mrs) cmd = CMD_LOADMODE;
    else             cmd = CMD_NOP;
  end

  sbs_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sbs_mode_word #(.RA_W(RA_W)) u_mode (
    .cas_lat(cfg_cas_lat), .word(mode_word)
  );

  sbs_cmd_drive #(.RA_W(RA_W), .BA_W(BA_W)) u_drive (
    .cmd(cmd), .mode_word(mode_word), .pins(pins), .ba(sd_ba), .addr(sd_addr)
  );

  assign sd_cs_n     = pins.cs_n;
  assign sd_ras_n    = pins.ras_n;
  assign sd_cas_n    = pins.cas_n;
  assign sd_we_n     = pins.we_n;
  assign stat_active = active_q;
  assign fwd_valid   = req_valid && active_q && !ack_q;
  assign req_ack     = ack_q || (active_q && eng_ack);

  // R7: status is sticky
  a_r7_active_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stat_active) |-> stat_active);
  // R9: nothing acknowledged or forwarded before bring-up ends
  a_r9_stall_before_active: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_active |-> (!req_ack && !fwd_valid));
  // R8: trigger write acknowledged with the rise of the status flag, not forwarded
  a_r8_ack_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_active) |-> (req_ack && !fwd_valid));
  // R12: pins idle once active
  a_r12_quiet_when_active: assert property (@(posedge clk) disable iff (!rst_n)
    stat_active |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111));
  // R5: never more refreshes than configured
  a_r5_ref_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ref |-> (ref_cnt_q < REF_LAST));
  // R6: mode load only after the full refresh train
  a_r6_mrs_after_refs: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mrs |-> (ref_cnt_q == REF_LAST));
  // R4: precharge addresses all banks
  a_r4_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pre |-> (sd_addr[10] && !sd_ras_n && sd_cas_n && !sd_we_n));

endmodule

// File: tb/sdram_boot_seq_tb.sv
module sdram_boot_seq_tb;
  localparam int RA = 13;
  localparam int PER_NS = 20;
  localparam int EXP_PU = (100000 + PER_NS - 1) / PER_NS;   // R3: 100 us at 20 ns
  localparam int EXP_RP = 3, EXP_RFC = 7, EXP_MRD = 2, EXP_NREF = 8;
  localparam logic [31:0] IN_ADDR  = 32'h4012_3450;
  localparam logic [31:0] OUT_ADDR = 32'h4212_3450;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_init = 1'b0;
  logic [1:0] cfg_cas_lat = 2'd3;
  logic req_valid = 1'b0, req_we = 1'b0, eng_ack = 1'b0;
  logic [31:0] req_addr = '0;
  logic req_ack, fwd_valid, stat_active;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_ba;
  logic [RA-1:0] sd_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(PER_NS/2) clk = ~clk;

  sdram_boot_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .cfg_cas_lat(cfg_cas_lat),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_ack(req_ack), .fwd_valid(fwd_valid), .eng_ack(eng_ack),
    .stat_active(stat_active), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
  );

  // Scoreboard items: kind 1 precharge, 2 refresh, 3 load mode, 5 active rise
  typedef struct {
    int kind;
    logic [RA-1:0] addr;
    int gap;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  bit mon_on = 0, kick = 0, prev_active = 0;
  int gap = 0, unexpected = 0;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int decode_pins();
    case ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n})
      4'b0111: return 0;
      4'b0010: return 1;
      4'b0001: return 2;
      4'b0000: return 3;
      default: return 4;
    endcase
  endfunction

  // Monitor: pops the queue as commands appear
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        int k;
        k = decode_pins();
        if (kick) begin
          kick = 0; gap = 0;
        end else if (stat_active && !prev_active) begin
          if (exp_q.size() == 0) check(0, "R7", "active rise unexpected", 1, 0);
          else begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.kind == 5, e.tag, "active rise kind", 5, e.kind);
            check(gap == e.gap, e.tag, "NOPs before active", gap, e.gap);
            check(req_ack && !fwd_valid, "R8", "trigger ack/fwd", {req_ack, fwd_valid}, 2);
          end
          gap = 0;
        end else if (k == 0) begin
          gap++;
        end else if (exp_q.size() == 0) begin
          unexpected++;
          check(0, "R12", "unexpected command", k, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(k == e.kind, e.tag, "command kind", k, e.kind);
          check(sd_addr == e.addr && sd_ba == 2'b00, e.tag, "command address", sd_addr, e.addr);
          check(gap == e.gap, e.tag, "NOP gap", gap, e.gap);
          gap = 0;
        end
        prev_active = stat_active;
      end
    end
  end

  task automatic drive(bit v, bit we, logic [31:0] a);
    @(posedge clk); #1;
    req_valid = v; req_we = we; req_addr = a;
  endtask

  task automatic push_train(logic [1:0] cas);
    exp_t e;
    e = '{kind: 1, addr: 13'h400, gap: EXP_PU, tag: "R3"};  exp_q.push_back(e);  // R4 precharge-all
    for (int i = 0; i < EXP_NREF; i++) begin
      e = '{kind: 2, addr: '0, gap: (i == 0) ? EXP_RP : EXP_RFC, tag: (i == 0) ? "R4" : "R5"};
      exp_q.push_back(e);
    end
    e = '{kind: 3, addr: RA'({1'b0, cas}) << 4, gap: EXP_RFC, tag: "R6"};  exp_q.push_back(e);
    e = '{kind: 5, addr: '0, gap: EXP_MRD, tag: "R7"};  exp_q.push_back(e);
  endtask

  task automatic run(logic [1:0] cas);
    bit ok;
    rst_n = 0; mon_on = 0; cfg_init = 0; cfg_cas_lat = cas;
    req_valid = 0; req_we = 0; eng_ack = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111 && !stat_active && !req_ack && !fwd_valid,
          "R1", "reset outputs", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, stat_active, req_ack, fwd_valid},
          7'b0111000);
    prev_active = 0; unexpected = 0; mon_on = 1;
    // R9: read before arming is held, not acked
    drive(1, 0, IN_ADDR);
    ok = 1;
    repeat (30) begin @(negedge clk); if (req_ack || fwd_valid) ok = 0; end
    check(ok, "R9", "held read acked early", !ok, 0);
    // R2: armed, but read in window and write outside window do not start
    cfg_init = 1;
    repeat (20) @(negedge clk);
    drive(1, 1, OUT_ADDR);
    repeat (30) @(negedge clk);
    drive(0, 0, '0);
    @(negedge clk);
    check(unexpected == 0 && exp_q.size() == 0, "R2", "commands without trigger", unexpected, 0);
    // trigger
    push_train(cas);
    @(posedge clk); #1;
    kick = 1; req_valid = 1; req_we = 1; req_addr = IN_ADDR;
    // R11: drop the init bit while the wait is running
    repeat (100) @(posedge clk);
    #1 cfg_init = 0;
    ok = 0;
    for (int i = 0; i < EXP_PU + 300; i++) begin
      @(negedge clk);
      if (stat_active) begin ok = 1; break; end
      if (req_ack || fwd_valid) check(0, "R9", "ack during bring-up", 1, 0);
    end
    check(ok, "R11", "sequence completed after init drop", ok, 1);
    check(exp_q.size() == 0, "R11", "items left in queue", exp_q.size(), 0);
    drive(0, 0, '0);
    @(negedge clk);
    check(!req_ack && stat_active, "R8", "ack single pulse", req_ack, 0);
    // R10: forwarding after active
    drive(1, 0, IN_ADDR);
    @(negedge clk);
    check(fwd_valid && !req_ack, "R10", "forward without engine ack", {fwd_valid, req_ack}, 2);
    @(posedge clk); #1 eng_ack = 1;
    @(negedge clk);
    check(req_ack, "R10", "engine ack passed", req_ack, 1);
    @(posedge clk); #1 eng_ack = 0; req_valid = 0;
    // R12: re-arm and trigger write while active
    cfg_init = 1;
    drive(1, 1, IN_ADDR);
    repeat (60) @(negedge clk);
    drive(0, 0, '0);
    @(negedge clk);
    check(unexpected == 0, "R12", "commands after re-arm", unexpected, 0);
    check(stat_active, "R7", "active stays set", stat_active, 1);
    mon_on = 0;
  endtask

  initial begin
    run(2'd3);
    run(2'd2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * PER_NS);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule